// File: doc/BRIEF.md
# I2C Slave Receiver with Overflow Refusal

This block is the target side of a two-wire serial bus. It watches the clock and data lines through synchronizers and recognises START and STOP conditions. It shifts in address and data bytes and hands each accepted byte to a single receive buffer, which a host reads through plain strobes. The block only ever pulls the data line low (open-drain enable). It does this to acknowledge a byte, and to send a zero bit when the bus master reads from it.

The block recognises a 7-bit own address, a 10-bit own address (selected by `mode[0]`) and, optionally, the all-zero general-call address. A byte that arrives while the receive buffer is still unread, or while an earlier overflow has not been cleared by the host, is refused. Such a byte is not acknowledged and not stored, but the byte interrupt flag is still raised so that the host learns something was lost. `mode[1]` adds interrupts on START and STOP. Clock stretching and bus mastering are not part of this block.

The controller has ten states:
- ST_IDLE: bus free.
- ST_ADDR: first address byte.
- ST_HI_ACK: acknowledge of a 10-bit first byte.
- ST_ADDR2: second 10-bit byte.
- ST_ADDR_ACK: acknowledge of a matched address.
- ST_RX: data byte.
- ST_RX_ACK: acknowledge of a data byte.
- ST_TX: sending a byte.
- ST_TX_ACK: master's acknowledge slot.
- ST_IGNORE: off the bus until the next START.

The transitions are:
- Any state goes to ST_ADDR on START and to ST_IDLE on STOP.
- ST_ADDR, when the byte ends, goes to ST_HI_ACK on a 10-bit high match, to ST_ADDR_ACK on an accepted 7-bit or general-call match, and otherwise to ST_IGNORE.
- ST_HI_ACK goes to ST_ADDR2 when SCL falls.
- ST_ADDR2, when the byte ends, goes to ST_ADDR_ACK on an accepted match and otherwise to ST_IGNORE.
- ST_ADDR_ACK, when SCL falls, goes to ST_TX for a read and to ST_RX for a write.
- ST_RX, when the byte ends, goes to ST_RX_ACK if the byte is accepted and otherwise to ST_IGNORE.
- ST_RX_ACK goes to ST_RX when SCL falls.
- ST_TX goes to ST_TX_ACK when the byte ends.
- ST_TX_ACK, when SCL falls, goes to ST_TX if the master acknowledged and otherwise to ST_IGNORE.

Top module: `i2c_slave_ovf`

## Requirements
- R1: After reset, `sda_oe`, `buf_full`, `ovf`, `irq`, `bus_s`, `bus_p` and `rw` are 0, and `rx_buf` is 0.
- R2: With `mode[0]`=0, an address byte whose upper seven bits equal `own_addr[6:0]` is acknowledged. Any other non-zero address byte is not acknowledged.
- R3: An accepted byte is acknowledged and copied to `rx_buf`, and it sets `buf_full` and `irq`. An accepted byte is a matched 7-bit or general-call address, the second byte of a matched 10-bit address, or a data byte after a match.
- R4: A byte that completes while `buf_full` is 1 is not acknowledged, leaves `rx_buf` unchanged and sets `ovf`.
- R5: A byte that completes while `ovf` is 1 is not acknowledged and leaves `rx_buf` unchanged, even when `buf_full` is 0.
- R6: In the refusal cases of R4 and R5, `irq` is still set. `irq` stays set until an `irq_clr` pulse.
- R7: An `rd_buf` pulse clears `buf_full`. `ovf` stays set through reads and is cleared only by an `ovf_clr` pulse.
- R8: With `mode[0]`=1, a first byte of the form 11110, `own_addr[9:8]`, R/W is acknowledged without being stored. A following byte equal to `own_addr[7:0]` is then handled as an accepted byte. Any other first or second byte is not acknowledged.
- R9: The address byte 0x00 is acknowledged as a write when `gc_en` is 1, and not acknowledged when `gc_en` is 0.
- R10: START sets `bus_s` and clears `bus_p`. STOP sets `bus_p` and clears `bus_s`. With `mode[1]`=1 each of them also sets `irq`. With `mode[1]`=0 they do not.
- R11: A repeated START drops the current match, so the next byte is checked again as an address.
- R12: A matched 7-bit address with R/W=1 sets `rw` and is acknowledged. The block then sends `tx_data` MSB first and sends it again after each master acknowledge. Each sent byte sets `irq`.
- R13: After an address that is not acknowledged, the block leaves SDA released for every later byte until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| mode | input | 2 | bit0: 10-bit addressing, bit1: START/STOP interrupts |
| gc_en | input | 1 | Enable general-call recognition |
| own_addr | input | 10 | Own slave address |
| tx_data | input | 8 | Byte to send on a read |
| rd_buf | input | 1 | Host read strobe of the receive buffer |
| ovf_clr | input | 1 | Host strobe clearing overflow |
| irq_clr | input | 1 | Host strobe clearing the interrupt flag |
| rx_buf | output | 8 | Receive buffer |
| buf_full | output | 1 | Buffer holds an unread byte |
| ovf | output | 1 | A byte was refused because the buffer was full |
| irq | output | 1 | Interrupt flag |
| bus_s | output | 1 | Last bus condition was START |
| bus_p | output | 1 | Last bus condition was STOP |
| rw | output | 1 | Current transfer is a read |

## Verification
Every bus result is due on the third clock edge after the pin edge that causes it: two synchronizer edges, then the edge that registers the state. An ACK or a sent bit therefore appears three cycles after the SCL fall that opens its slot. Buffer, overflow and flag updates follow three cycles after the eighth bit's falling edge, and host strobes take effect on the next edge. The bench holds each SCL half-period for eight clocks, reads SDA in the middle of the high phase, and checks registers only after a byte task or strobe task has returned, so every sample falls well after the result is due.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int BYTE_W      = 8;
    localparam int OWN_W       = 10;
    localparam int MODE_TEN    = 0;
    localparam int MODE_SP     = 1;
    localparam logic [4:0] TEN_TAG = 5'b11110;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_ADDR     = 4'd1,
        ST_HI_ACK   = 4'd2,
        ST_ADDR2    = 4'd3,
        ST_ADDR_ACK = 4'd4,
        ST_RX       = 4'd5,
        ST_RX_ACK   = 4'd6,
        ST_TX       = 4'd7,
        ST_TX_ACK   = 4'd8,
        ST_IGNORE   = 4'd9
    } state_t;

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cs_bus_cond.sv
module i2cs_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2cs_addr_match.sv
module i2cs_addr_match
    import i2cs_pkg::*;
(
    input  logic [BYTE_W-1:0] sh,
    input  logic [OWN_W-1:0]  own_addr,
    input  logic              gc_en,
    input  logic              ten,
    output logic              hit7,
    output logic              gc_hit,
    output logic              hit10_hi,
    output logic              hit10_lo
);
    always_comb begin
        hit7     = !ten && (sh[BYTE_W-1:1] == own_addr[BYTE_W-2:0]);
        gc_hit   = gc_en && (sh == '0);
        hit10_hi = ten && (sh[BYTE_W-1:3] == TEN_TAG)
                       && (sh[2:1] == own_addr[OWN_W-1:BYTE_W]);
        hit10_lo = (sh == own_addr[BYTE_W-1:0]);
    end
endmodule

// File: rtl/i2c_slave_ovf.sv
module i2c_slave_ovf
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [1:0]        mode,
    input  logic              gc_en,
    input  logic [OWN_W-1:0]  own_addr,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              rd_buf,
    input  logic              ovf_clr,
    input  logic              irq_clr,
    output logic [BYTE_W-1:0] rx_buf,
    output logic              buf_full,
    output logic              ovf,
    output logic              irq,
    output logic              bus_s,
    output logic              bus_p,
    output logic              rw
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(BYTE_W);

    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_det, stop_det;
    logic hit7, gc_hit, hit10_hi, hit10_lo;

    state_t st, st_nx;
    logic [BYTE_W-1:0] sh, tx_sh;
    logic [CNT_W-1:0]  bitcnt;
    logic              m_ack;
    logic              ten, sp_ie;
    logic              byte_end, bus_evt, room, take, shifting, tx_done;

    i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
        .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s)
    );
    i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
        .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s)
    );

    i2cs_bus_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cs_addr_match u_match (
        .sh(sh), .own_addr(own_addr), .gc_en(gc_en), .ten(ten),
        .hit7(hit7), .gc_hit(gc_hit), .hit10_hi(hit10_hi), .hit10_lo(hit10_lo)
    );

    assign ten   = mode[MODE_TEN];
    assign sp_ie = mode[MODE_SP];

    always_comb begin
        bus_evt  = start_det | stop_det;
        byte_end = scl_fall && (bitcnt == CNT_END) && !bus_evt;
        room     = !buf_full && !ovf;
        take     = byte_end && (((st == ST_ADDR) && (hit7 || gc_hit))
                             || ((st == ST_ADDR2) && hit10_lo)
                             || (st == ST_RX));
        tx_done  = byte_end && (st == ST_TX);
        shifting = (st == ST_ADDR) || (st == ST_ADDR2)
                || (st == ST_RX)   || (st == ST_TX);
    end

    // next-state decision
    always_comb begin
        st_nx = st;
        if (start_det) begin
            st_nx = ST_ADDR;
        end else if (stop_det) begin
            st_nx = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE, ST_IGNORE: st_nx = st;
                ST_ADDR: begin
                    if (byte_end) begin
                        if (hit10_hi)                     st_nx = ST_HI_ACK;
                        else if ((hit7 || gc_hit) && room) st_nx = ST_ADDR_ACK;
                        else                              st_nx = ST_IGNORE;
                    end
                end
                ST_HI_ACK:   if (scl_fall) st_nx = ST_ADDR2;
                ST_ADDR2:    if (byte_end) st_nx = (hit10_lo && room) ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) st_nx = rw ? ST_TX : ST_RX;
                ST_RX:       if (byte_end) st_nx = room ? ST_RX_ACK : ST_IGNORE;
                ST_RX_ACK:   if (scl_fall) st_nx = ST_RX;
                ST_TX:       if (byte_end) st_nx = ST_TX_ACK;
                ST_TX_ACK:   if (scl_fall) st_nx = m_ack ? ST_TX : ST_IGNORE;
                default:     st_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // output process: open-drain data enable
    always_comb begin
        unique case (st)
            ST_HI_ACK, ST_ADDR_ACK, ST_RX_ACK: sda_oe = 1'b1;
            ST_TX:                             sda_oe = ~tx_sh[BYTE_W-1];
            default:                           sda_oe = 1'b0;
        endcase
    end

    // shift path and byte counting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh     <= '0;
            bitcnt <= '0;
            tx_sh  <= '1;
            m_ack  <= 1'b0;
            rw     <= 1'b0;
        end else begin
            if ((st_nx != st) || start_det) begin
                bitcnt <= '0;
            end else if (scl_rise && shifting && (bitcnt < CNT_END)) begin
                sh     <= {sh[BYTE_W-2:0], sda_s};
                bitcnt <= bitcnt + 1'b1;
            end

            if ((st_nx == ST_TX) && (st != ST_TX))
                tx_sh <= tx_data;
            else if ((st == ST_TX) && scl_fall)
                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b1};

            if ((st == ST_TX_ACK) && scl_rise)
                m_ack <= ~sda_s;

            if (byte_end && (st == ST_ADDR))
                rw <= hit7 & sh[0];
            else if (byte_end && (st == ST_ADDR2))
                rw <= 1'b0;
        end
    end

    // receive buffer, overflow and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_buf   <= '0;
            buf_full <= 1'b0;
            ovf      <= 1'b0;
            irq      <= 1'b0;
            bus_s    <= 1'b0;
            bus_p    <= 1'b0;
        end else begin
            if (take && room) begin
                rx_buf   <= sh;
                buf_full <= 1'b1;
            end else if (rd_buf) begin
                buf_full <= 1'b0;
            end

            if (take && buf_full) ovf <= 1'b1;
            else if (ovf_clr)     ovf <= 1'b0;

            if (take || tx_done || (sp_ie && bus_evt)) irq <= 1'b1;
            else if (irq_clr)                          irq <= 1'b0;

            if (start_det) begin
                bus_s <= 1'b1;
                bus_p <= 1'b0;
            end else if (stop_det) begin
                bus_s <= 1'b0;
                bus_p <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker
    import i2cs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [BYTE_W-1:0] rx_buf,
    input logic              buf_full,
    input logic              ovf,
    input logic              irq,
    input logic              rd_buf,
    input logic              ovf_clr,
    input logic              irq_clr,
    input logic              bus_s,
    input logic              bus_p
);
    assert_load_sets_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_full) |-> irq);

    assert_full_freezes_buf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full |=> $stable(rx_buf));

    assert_ovf_needs_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(buf_full));

    assert_ovf_freezes_buf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> $stable(rx_buf));

    assert_ovf_raises_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> irq);

    assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);

    assert_read_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_buf && buf_full) |=> !buf_full);

    assert_cond_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_s && bus_p));
endmodule

bind i2c_slave_ovf i2cs_checker u_chk (
    .clk(clk), .rst_n(rst_n), .rx_buf(rx_buf), .buf_full(buf_full),
    .ovf(ovf), .irq(irq), .rd_buf(rd_buf), .ovf_clr(ovf_clr),
    .irq_clr(irq_clr), .bus_s(bus_s), .bus_p(bus_p)
);

// File: tb/tb_i2c_slave_ovf.sv
module tb_i2c_slave_ovf;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int WD_CYCLES  = 150000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       scl_m, sda_m;
    logic       sda_oe;
    wire        sda_line = sda_m & ~sda_oe;
    logic [1:0] mode;
    logic       gc_en;
    logic [9:0] own_addr;
    logic [7:0] tx_data;
    logic       rd_buf, ovf_clr, irq_clr;
    logic [7:0] rx_buf;
    logic       buf_full, ovf, irq, bus_s, bus_p, rw;

    int         total = 0;
    int         bad   = 0;
    logic       ack;
    logic [7:0] rb;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_slave_ovf dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .mode(mode), .gc_en(gc_en), .own_addr(own_addr),
        .tx_data(tx_data), .rd_buf(rd_buf), .ovf_clr(ovf_clr), .irq_clr(irq_clr),
        .rx_buf(rx_buf), .buf_full(buf_full), .ovf(ovf), .irq(irq),
        .bus_s(bus_s), .bus_p(bus_p), .rw(rw)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; tick(HALF);
        scl_m = 1'b1; tick(HALF);
        sda_m = 1'b0; tick(HALF);
        scl_m = 1'b0; tick(HALF);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; tick(HALF);
        scl_m = 1'b1; tick(HALF);
        sda_m = 1'b1; tick(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic a);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(HALF);
            scl_m = 1'b1; tick(HALF);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; tick(HALF);
        scl_m = 1'b1; tick(HALF/2);
        a = ~sda_line; tick(HALF/2);
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(HALF);
            scl_m = 1'b1; tick(HALF/2);
            b[i] = sda_line; tick(HALF/2);
            scl_m = 1'b0;
        end
        sda_m = ~give_ack; tick(HALF);
        scl_m = 1'b1; tick(HALF);
        scl_m = 1'b0;
    endtask

    task automatic pulse_rd();
        @(negedge clk) rd_buf = 1'b1;
        @(negedge clk) rd_buf = 1'b0;
    endtask

    task automatic pulse_ovf_clr();
        @(negedge clk) ovf_clr = 1'b1;
        @(negedge clk) ovf_clr = 1'b0;
    endtask

    task automatic pulse_irq_clr();
        @(negedge clk) irq_clr = 1'b1;
        @(negedge clk) irq_clr = 1'b0;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
        mode = 2'b00; gc_en = 1'b1; own_addr = 10'h03A; tx_data = 8'h00;
        rd_buf = 1'b0; ovf_clr = 1'b0; irq_clr = 1'b0;
        tick(5);
        rst_n = 1'b1;
        tick(4);

        // R1: reset state
        chk("R1 flags", {25'd0, sda_oe, buf_full, ovf, irq, bus_s, bus_p, rw}, 32'd0);
        chk("R1 rx_buf", rx_buf, 8'h00);

        // R2 / R9 / R3: sweep of every 7-bit write address
        for (int a = 0; a < 128; a++) begin
            logic exp_ack;
            exp_ack = (a == 32'h3A) || (a == 0);
            i2c_start();
            send_byte({7'(a), 1'b0}, ack);
            chk((a == 0) ? "R9 general call ack" : "R2 address ack", ack, exp_ack);
            if (ack) begin
                chk("R3 address stored", rx_buf, {7'(a), 1'b0});
                chk("R3 buf_full set", buf_full, 1'b1);
                pulse_rd();
            end
            i2c_stop();
        end

        // R9: general call refused when disabled
        gc_en = 1'b0;
        i2c_start();
        send_byte(8'h00, ack);
        chk("R9 general call off", ack, 1'b0);
        i2c_stop();
        gc_en = 1'b1;

        // R3 R4 R5 R6 R7: buffer, overflow and refusal
        pulse_irq_clr();
        i2c_start();
        send_byte(8'h74, ack);
        chk("R3 addr ack", ack, 1'b1);
        pulse_rd();
        pulse_irq_clr();
        send_byte(8'hA5, ack);
        chk("R3 data ack", ack, 1'b1);
        chk("R3 data stored", rx_buf, 8'hA5);
        chk("R3 buf_full", buf_full, 1'b1);
        chk("R3 irq", irq, 1'b1);
        pulse_irq_clr();
        send_byte(8'h3C, ack);
        chk("R4 nack when full", ack, 1'b0);
        chk("R4 buffer kept", rx_buf, 8'hA5);
        chk("R4 ovf set", ovf, 1'b1);
        chk("R6 irq on refusal", irq, 1'b1);
        i2c_stop();
        pulse_rd();
        chk("R7 read clears full", buf_full, 1'b0);
        chk("R7 ovf survives read", ovf, 1'b1);
        pulse_irq_clr();
        chk("R6 irq cleared", irq, 1'b0);
        i2c_start();
        send_byte(8'h74, ack);
        chk("R5 nack on ovf", ack, 1'b0);
        chk("R5 buffer kept", rx_buf, 8'hA5);
        chk("R5 buf_full stays clear", buf_full, 1'b0);
        chk("R6 irq on ovf refusal", irq, 1'b1);
        i2c_stop();
        pulse_ovf_clr();
        chk("R7 ovf cleared by write", ovf, 1'b0);
        i2c_start();
        send_byte(8'h74, ack);
        chk("R7 ack after clear", ack, 1'b1);
        pulse_rd();
        i2c_stop();

        // R11 / R13: repeated start re-evaluates the address
        i2c_start();
        send_byte(8'h74, ack);
        chk("R11 first match", ack, 1'b1);
        pulse_rd();
        i2c_start();
        send_byte(8'h76, ack);
        chk("R11 new address checked", ack, 1'b0);
        send_byte(8'h55, ack);
        chk("R13 released after nack", ack, 1'b0);
        chk("R13 buffer untouched", rx_buf, 8'h74);
        i2c_stop();

        // R12: read transfer
        tx_data = 8'h96;
        pulse_irq_clr();
        i2c_start();
        send_byte(8'h75, ack);
        chk("R12 read addr ack", ack, 1'b1);
        chk("R12 rw set", rw, 1'b1);
        pulse_rd();
        pulse_irq_clr();
        recv_byte(1'b1, rb);
        tx_data = 8'h5B;
        chk("R12 first byte", rb, 8'h96);
        chk("R12 irq per sent byte", irq, 1'b1);
        recv_byte(1'b0, rb);
        chk("R12 second byte", rb, 8'h5B);
        i2c_stop();

        // R8: 10-bit addressing
        mode = 2'b01;
        own_addr = 10'h2C5;
        i2c_start();
        send_byte(8'hF4, ack);
        chk("R8 high byte ack", ack, 1'b1);
        chk("R8 high byte not stored", buf_full, 1'b0);
        send_byte(8'hC5, ack);
        chk("R8 low byte ack", ack, 1'b1);
        chk("R8 low byte stored", rx_buf, 8'hC5);
        pulse_rd();
        send_byte(8'h11, ack);
        chk("R8 data ack", ack, 1'b1);
        chk("R8 data stored", rx_buf, 8'h11);
        pulse_rd();
        i2c_stop();
        i2c_start();
        send_byte(8'hF4, ack);
        chk("R8 high byte ack again", ack, 1'b1);
        send_byte(8'hC4, ack);
        chk("R8 wrong low byte", ack, 1'b0);
        i2c_stop();
        i2c_start();
        send_byte(8'hF2, ack);
        chk("R8 wrong high byte", ack, 1'b0);
        i2c_stop();
        i2c_start();
        send_byte(8'h8A, ack);
        chk("R8 7-bit form refused", ack, 1'b0);
        i2c_stop();

        // R10: bus conditions and their interrupts
        mode = 2'b10;
        own_addr = 10'h03A;
        pulse_irq_clr();
        i2c_start();
        chk("R10 start flags", {bus_s, bus_p}, 2'b10);
        chk("R10 start irq", irq, 1'b1);
        pulse_irq_clr();
        i2c_stop();
        chk("R10 stop flags", {bus_s, bus_p}, 2'b01);
        chk("R10 stop irq", irq, 1'b1);
        mode = 2'b00;
        pulse_irq_clr();
        i2c_start();
        chk("R10 start flags no irq", {bus_s, bus_p, irq}, 3'b100);
        i2c_stop();
        chk("R10 stop flags no irq", {bus_s, bus_p, irq}, 3'b010);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule